// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the pending-event flags of an eight-channel capture/compare timer. A channel register holds one flag per channel, and an overflow register keeps the counter wrap flag in its top bit. Each flag is set by a single-cycle event pulse from the timer datapath. Software clears a flag by writing a one to its bit.

A fast-clear option lets software skip the explicit clear write. When `fast_clr_en_i` is high during an access, the flag is cleared as a side effect of the access that services the event:
- a capture channel's flag clears when that channel's data register is read;
- a compare channel's flag clears when that channel's data register is written;
- the overflow flag clears on any access to the counter.

Per-channel and overflow interrupt requests are the flags masked by enable inputs, and they are ORed into one interrupt line.

Default map (8-bit byte addresses):
- counter: 0x04–0x05;
- channel flag register: 0x0E;
- overflow flag register: 0x0F;
- channel data registers: 0x10–0x1F, with channel n at 0x10+2n (low byte) and 0x11+2n (high byte).

Top module: `tfc_flag_ctl`

## Requirements
- R1: After reset, asserted at any time, both flag registers are zero and every interrupt output is low.
- R2: A high bit of `ch_evt_i` sets channel flag n at the next clock edge, and `ovf_evt_i` sets the overflow flag at the next clock edge. Flags hold their value when nothing acts on them.
- R3: A write to address 0x0E clears each channel flag whose `wdata_i` bit is one, with bit n for channel n. Flags whose data bit is zero are unchanged.
- R4: A write to address 0x0F with `wdata_i[7]`=1 clears the overflow flag, and with bit 7 zero it leaves the flag unchanged. A read of 0x0F returns the flag in bit 7 and zero in bits 6..0.
- R5: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R6: With fast-clear enabled and `ch_is_cmp_i[n]`=0 (capture), a read of either byte of channel n's register clears flag n. A write to that register does not clear it.
- R7: With fast-clear enabled and `ch_is_cmp_i[n]`=1 (compare), a write to either byte of channel n's register clears flag n. A read of that register does not clear it.
- R8: With fast-clear enabled, a read or write of either counter byte (0x04, 0x05) clears the overflow flag.
- R9: With `fast_clr_en_i` low, reads and writes of channel or counter addresses leave all flags unchanged.
- R10: `ch_irq_o[n]` = flag n AND `ch_ie_i[n]`, `ovf_irq_o` = overflow flag AND `ovf_ie_i`, and `irq_o` is the OR of all of these. The outputs are combinational from the flag registers.
- R11: `rdata_o` is combinational. It returns the channel flags at 0x0E and the overflow register at 0x0F while `rd_i` is high. It is zero at any other address or when `rd_i` is low. Reading a flag register does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_evt_i | input | 8 | Per-channel event pulses |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| addr_i | input | 8 | Register bus byte address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| fast_clr_en_i | input | 1 | Fast-clear mode enable |
| ch_is_cmp_i | input | 8 | Per-channel mode, 1 = compare, 0 = capture |
| ch_ie_i | input | 8 | Channel interrupt enables |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ch_flag_o | output | 8 | Channel flags |
| ovf_flag_o | output | 1 | Overflow flag |
| rdata_o | output | 8 | Read data |
| ch_irq_o | output | 8 | Masked channel requests |
| ovf_irq_o | output | 1 | Masked overflow request |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a flag that is set and cleared in the same cycle, because an event pulse has to coincide exactly with a clearing access. The bench covers both forms of this: a write-one-to-clear combined with new events, and a fast-clear counter read combined with an overflow pulse. Both are single rows of the stimulus table, so the coincidence is fixed by construction and does not rely on timing luck. The opposite-direction accesses (reading a compare channel, writing a capture channel) and accesses with fast-clear disabled come between real clears, so a flag that changes wrongly shows up at once.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int unsigned NUM_CH_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam logic [7:0] CNT_ADDR_DEF     = 8'h04;
  localparam logic [7:0] FLG_CH_ADDR_DEF  = 8'h0E;
  localparam logic [7:0] FLG_OVF_ADDR_DEF = 8'h0F;
  localparam logic [7:0] CH_BASE_DEF      = 8'h10;
endpackage

// File: rtl/tfc_decode.sv
module tfc_decode #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CNT_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLG_CH_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLG_OVF_ADDR = '0,
  parameter logic [ADDR_W-1:0] CH_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic              fast_clr_en_i,
  input  logic [NUM_CH-1:0] ch_is_cmp_i,
  output logic [NUM_CH-1:0] ch_clr_o,
  output logic              ovf_clr_o,
  output logic              sel_ch_o,
  output logic              sel_ovf_o
);
  localparam logic [ADDR_W-1:0] BLK_BYTES = ADDR_W'(2 * NUM_CH);
  localparam logic [ADDR_W-1:0] CNT_HI    = ADDR_W'(CNT_ADDR + 1);

  logic [ADDR_W-1:0] off;
  logic              in_blk;
  logic              cnt_hit;
  logic [NUM_CH-1:0] fast_ch_clr;

  assign sel_ch_o  = addr_i == FLG_CH_ADDR;
  assign sel_ovf_o = addr_i == FLG_OVF_ADDR;
  assign off       = addr_i - CH_BASE;
  assign in_blk    = off < BLK_BYTES;
  assign cnt_hit   = (addr_i == CNT_ADDR) || (addr_i == CNT_HI);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic hit;
    assign hit = in_blk && (off[ADDR_W-1:1] == (ADDR_W-1)'(n));
    // compare channels clear on write, capture channels on read
    assign fast_ch_clr[n] = fast_clr_en_i && hit && (ch_is_cmp_i[n] ? wr_i : rd_i);
  end

  assign ch_clr_o  = ((wr_i && sel_ch_o) ? wdata_i : '0) | fast_ch_clr;
  assign ovf_clr_o = (wr_i && sel_ovf_o && wdata_i[NUM_CH-1]) ||
                     (fast_clr_en_i && cnt_hit && (rd_i || wr_i));
endmodule

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[b] <= 1'b0;
      else if (set_i[b]) q_o[b] <= 1'b1;   // set dominates clear
      else if (clr_i[b]) q_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/tfc_irq.sv
module tfc_irq #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] ch_flag_i,
  input  logic [NUM_CH-1:0] ch_ie_i,
  input  logic              ovf_flag_i,
  input  logic              ovf_ie_i,
  output logic [NUM_CH-1:0] ch_irq_o,
  output logic              ovf_irq_o,
  output logic              irq_o
);
  assign ch_irq_o  = ch_flag_i & ch_ie_i;
  assign ovf_irq_o = ovf_flag_i & ovf_ie_i;
  assign irq_o     = (|ch_irq_o) | ovf_irq_o;
endmodule

// File: rtl/tfc_flag_ctl.sv
module tfc_flag_ctl #(
  parameter int unsigned NUM_CH = tfc_pkg::NUM_CH_DEF,
  parameter int unsigned ADDR_W = tfc_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] CNT_ADDR     = ADDR_W'(tfc_pkg::CNT_ADDR_DEF),
  parameter logic [ADDR_W-1:0] FLG_CH_ADDR  = ADDR_W'(tfc_pkg::FLG_CH_ADDR_DEF),
  parameter logic [ADDR_W-1:0] FLG_OVF_ADDR = ADDR_W'(tfc_pkg::FLG_OVF_ADDR_DEF),
  parameter logic [ADDR_W-1:0] CH_BASE      = ADDR_W'(tfc_pkg::CH_BASE_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ch_evt_i,
  input  logic              ovf_evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic              fast_clr_en_i,
  input  logic [NUM_CH-1:0] ch_is_cmp_i,
  input  logic [NUM_CH-1:0] ch_ie_i,
  input  logic              ovf_ie_i,
  output logic [NUM_CH-1:0] ch_flag_o,
  output logic              ovf_flag_o,
  output logic [NUM_CH-1:0] rdata_o,
  output logic [NUM_CH-1:0] ch_irq_o,
  output logic              ovf_irq_o,
  output logic              irq_o
);
  localparam int unsigned DATA_W = NUM_CH;

  logic [NUM_CH-1:0] ch_clr;
  logic              ovf_clr;
  logic              sel_ch;
  logic              sel_ovf;

  tfc_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR),
    .FLG_CH_ADDR(FLG_CH_ADDR), .FLG_OVF_ADDR(FLG_OVF_ADDR), .CH_BASE(CH_BASE)
  ) i_decode (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .fast_clr_en_i(fast_clr_en_i), .ch_is_cmp_i(ch_is_cmp_i),
    .ch_clr_o(ch_clr), .ovf_clr_o(ovf_clr), .sel_ch_o(sel_ch), .sel_ovf_o(sel_ovf)
  );

  tfc_flag_bank #(.WIDTH(NUM_CH)) i_ch_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ch_evt_i), .clr_i(ch_clr), .q_o(ch_flag_o)
  );

  tfc_flag_bank #(.WIDTH(1)) i_ovf_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_evt_i), .clr_i(ovf_clr), .q_o(ovf_flag_o)
  );

  tfc_irq #(.NUM_CH(NUM_CH)) i_irq (
    .ch_flag_i(ch_flag_o), .ch_ie_i(ch_ie_i), .ovf_flag_i(ovf_flag_o),
    .ovf_ie_i(ovf_ie_i), .ch_irq_o(ch_irq_o), .ovf_irq_o(ovf_irq_o), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && sel_ch)  rdata_o = ch_flag_o;
    if (rd_i && sel_ovf) rdata_o = {ovf_flag_o, {(DATA_W-1){1'b0}}};
  end
endmodule

// File: rtl/tfc_flag_chk.sv
module tfc_flag_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLG_CH_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLG_OVF_ADDR = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ch_evt_i,
  input logic              ovf_evt_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              fast_clr_en_i,
  input logic [NUM_CH-1:0] ch_ie_i,
  input logic [NUM_CH-1:0] ch_flag_o,
  input logic              ovf_flag_o,
  input logic [NUM_CH-1:0] rdata_o,
  input logic [NUM_CH-1:0] ch_irq_o,
  input logic              ovf_irq_o,
  input logic              irq_o
);
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |ch_evt_i |=> ((ch_flag_o & $past(ch_evt_i)) == $past(ch_evt_i))); // R5
  AST_OVF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_flag_o); // R2
  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ch_flag_o & ~$past(ch_flag_o) & ~$past(ch_evt_i)) == '0)); // R2
  AST_FAST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_clr_en_i && !(wr_i && addr_i == FLG_CH_ADDR))
      |=> ((ch_flag_o & $past(ch_flag_o)) == $past(ch_flag_o))); // R9
  AST_OVF_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == FLG_OVF_ADDR) |-> (rdata_o[NUM_CH-2:0] == '0)); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ch_irq_o & ~ch_ie_i) == '0) && ((ch_irq_o & ~ch_flag_o) == '0)); // R10
  AST_OVF_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> ovf_flag_o); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|ch_flag_o || ovf_flag_o)); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0)); // R11
endmodule

bind tfc_flag_ctl tfc_flag_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
  .FLG_CH_ADDR(FLG_CH_ADDR), .FLG_OVF_ADDR(FLG_OVF_ADDR)
) i_tfc_flag_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ch_evt_i(ch_evt_i), .ovf_evt_i(ovf_evt_i),
  .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .fast_clr_en_i(fast_clr_en_i),
  .ch_ie_i(ch_ie_i), .ch_flag_o(ch_flag_o), .ovf_flag_o(ovf_flag_o),
  .rdata_o(rdata_o), .ch_irq_o(ch_irq_o), .ovf_irq_o(ovf_irq_o), .irq_o(irq_o)
);

// File: tb/test_tfc_flag_ctl.sv
module test_tfc_flag_ctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ch_evt_i = '0;
  logic       ovf_evt_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       fast_clr_en_i = 1'b0;
  logic [7:0] ch_is_cmp_i = 8'hF0;   // ch7..4 compare, ch3..0 capture
  logic [7:0] ch_ie_i = '0;
  logic       ovf_ie_i = 1'b0;
  logic [7:0] ch_flag_o;
  logic       ovf_flag_o;
  logic [7:0] rdata_o;
  logic [7:0] ch_irq_o;
  logic       ovf_irq_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tfc_flag_ctl i_tfc_flag_ctl (.*);

  typedef struct packed {
    logic [7:0] evt;
    logic       ovf;
    logic [7:0] addr;
    logic       rd;
    logic       wr;
    logic [7:0] wd;
    logic       fc;
    logic [7:0] exp_ch;
    logic       exp_ovf;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{8'hA5,1'b0,8'h00,1'b0,1'b0,8'h00,1'b0,8'hA5,1'b0,4'd2},  // R2 events
    '{8'h00,1'b1,8'h00,1'b0,1'b0,8'h00,1'b0,8'hA5,1'b1,4'd2},  // R2 overflow
    '{8'h00,1'b0,8'h0E,1'b0,1'b1,8'h05,1'b0,8'hA0,1'b1,4'd3},  // R3 w1c
    '{8'h00,1'b0,8'h0E,1'b0,1'b1,8'h00,1'b0,8'hA0,1'b1,4'd3},  // R3 zero write
    '{8'h00,1'b0,8'h0F,1'b0,1'b1,8'h7F,1'b0,8'hA0,1'b1,4'd4},  // R4 low bits ignored
    '{8'h00,1'b0,8'h0F,1'b0,1'b1,8'h80,1'b0,8'hA0,1'b0,4'd4},  // R4 bit7 clears
    '{8'h0F,1'b0,8'h0E,1'b0,1'b1,8'hFF,1'b0,8'h0F,1'b0,4'd5},  // R5 set wins
    '{8'h00,1'b0,8'h10,1'b1,1'b0,8'h00,1'b0,8'h0F,1'b0,4'd9},  // R9 fast off
    '{8'h00,1'b0,8'h11,1'b1,1'b0,8'h00,1'b1,8'h0E,1'b0,4'd6},  // R6 ch0 high byte read
    '{8'h00,1'b0,8'h12,1'b0,1'b1,8'h00,1'b1,8'h0E,1'b0,4'd6},  // R6 capture write ignored
    '{8'h00,1'b0,8'h12,1'b1,1'b0,8'h00,1'b1,8'h0C,1'b0,4'd6},  // R6 ch1 read
    '{8'hF0,1'b0,8'h00,1'b0,1'b0,8'h00,1'b0,8'hFC,1'b0,4'd2},  // R2
    '{8'h00,1'b0,8'h1E,1'b1,1'b0,8'h00,1'b1,8'hFC,1'b0,4'd7},  // R7 compare read ignored
    '{8'h00,1'b0,8'h1F,1'b0,1'b1,8'h00,1'b1,8'h7C,1'b0,4'd7},  // R7 ch7 write
    '{8'h00,1'b0,8'h18,1'b0,1'b1,8'h00,1'b0,8'h7C,1'b0,4'd9},  // R9
    '{8'h00,1'b0,8'h18,1'b0,1'b1,8'h00,1'b1,8'h6C,1'b0,4'd7},  // R7 ch4 write
    '{8'h00,1'b1,8'h00,1'b0,1'b0,8'h00,1'b0,8'h6C,1'b1,4'd2},  // R2
    '{8'h00,1'b0,8'h04,1'b1,1'b0,8'h00,1'b0,8'h6C,1'b1,4'd9},  // R9 counter
    '{8'h00,1'b0,8'h05,1'b1,1'b0,8'h00,1'b1,8'h6C,1'b0,4'd8},  // R8 read
    '{8'h00,1'b1,8'h00,1'b0,1'b0,8'h00,1'b0,8'h6C,1'b1,4'd2},  // R2
    '{8'h00,1'b0,8'h04,1'b0,1'b1,8'h00,1'b1,8'h6C,1'b0,4'd8},  // R8 write
    '{8'h00,1'b1,8'h04,1'b1,1'b0,8'h00,1'b1,8'h6C,1'b1,4'd5}   // R5 overflow set wins
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ch_evt_i = '0; ovf_evt_i = 1'b0; addr_i = '0; rd_i = 1'b0;
    wr_i = 1'b0; wdata_i = '0; fast_clr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset flags", {ovf_flag_o, ch_flag_o}, 9'h000);
    check("R1 reset irq", {irq_o, ch_irq_o}, 9'h000);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      ch_evt_i = VEC[i].evt; ovf_evt_i = VEC[i].ovf; addr_i = VEC[i].addr;
      rd_i = VEC[i].rd; wr_i = VEC[i].wr; wdata_i = VEC[i].wd;
      fast_clr_en_i = VEC[i].fc;
      @(posedge clk_i);
      #1;
      check($sformatf("R%0d vec%0d", VEC[i].req, i),
            {ovf_flag_o, ch_flag_o}, {VEC[i].exp_ovf, VEC[i].exp_ch});
    end

    // flags now ch=6C, ovf=1
    @(negedge clk_i);
    idle();
    addr_i = 8'h0E; rd_i = 1'b1;
    #1 check("R11 read channel flags", {1'b0, rdata_o}, 9'h06C);
    addr_i = 8'h0F;
    #1 check("R4 read overflow reg", {1'b0, rdata_o}, 9'h080);
    addr_i = 8'h20;
    #1 check("R11 unmapped read", {1'b0, rdata_o}, 9'h000);
    addr_i = 8'h0E; rd_i = 1'b0;
    #1 check("R11 no strobe", {1'b0, rdata_o}, 9'h000);
    rd_i = 1'b1;
    @(posedge clk_i); #1;
    check("R11 read has no side effect", {ovf_flag_o, ch_flag_o}, 9'h16C);

    @(negedge clk_i);
    idle();
    ch_ie_i = 8'h0C; ovf_ie_i = 1'b0;
    #1 check("R10 channel irq", {irq_o, ch_irq_o}, 9'h10C);
    check("R10 ovf irq masked", {8'h00, ovf_irq_o}, 9'h000);
    ch_ie_i = 8'h00; ovf_ie_i = 1'b1;
    #1 check("R10 ovf irq", {irq_o, 7'h00, ovf_irq_o}, 9'h101);
    ch_ie_i = 8'h01; ovf_ie_i = 1'b0;
    #1 check("R10 enable without flag", {irq_o, ch_irq_o}, 9'h000);

    ch_ie_i = 8'hFF; ovf_ie_i = 1'b1;
    rst_ni = 1'b0;
    #1 check("R1 async reset flags", {ovf_flag_o, ch_flag_o}, 9'h000);
    check("R1 async reset irq", {irq_o, ch_irq_o}, 9'h000);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule